// File: doc/BRIEF.md
# Sleep-Mode Magic Packet Wake Detector

This block sits beside an Ethernet receive path and watches the byte stream of received frames while the MAC is asleep. When a frame carries a wake-up pattern and is addressed to the node, the block raises a wake-up indication. The pattern is a run of six 0xFF bytes followed by sixteen back-to-back copies of the node's own station address. A frame is addressed to the node when its destination is a group address, the primary station address, or an enabled supplemental unicast address. The detector only runs while the node is asleep and the magic-enable bit is set. It also drives the gating lines that hold transmit, the FIFOs and the statistics counters off during sleep.

Sleep is entered in either of two ways: through the `cfg_sleep` control bit, or through the `ext_stop` pin. The pin acts directly and does not change any control bit. Each frame goes through a matching state machine with these states:

- `ST_OFF`: detection is inactive.
- `ST_WAIT`: waiting for a frame start.
- `ST_HDR`: the 12 header bytes, which are the destination and source addresses.
- `ST_SKIP`: the rest of a frame whose destination was rejected.
- `ST_SYNC`: counting the 0xFF synchronisation run.
- `ST_ADDR`: matching the address copies.
- `ST_FOUND`: the pattern is complete and the machine waits for the end of the frame.

The transitions are as follows:

- OFF to WAIT when detection becomes active.
- Any state to OFF when detection becomes inactive.
- Any state except OFF to HDR on a start byte.
- HDR to SKIP on the first source byte if the destination failed the filter.
- HDR to SYNC after the last header byte.
- SYNC to ADDR on the first address byte after a full run.
- ADDR to SYNC on a mismatch.
- ADDR to FOUND when the last copy completes.
- Any state to WAIT on an end byte. This is where a detection is reported if the state is, or becomes, FOUND.

Top module: `sleep_wake_detector`

## Requirements
- R1: `sleep_active`, `tx_disable`, `fifo_disable` and `stat_inhibit` are high exactly when `cfg_sleep` or `ext_stop` is high. Once `ext_stop` falls with `cfg_sleep` low, they return low.
- R2: A wake-up is detected only while `sleep_active` and `cfg_magic_en` are both high.
- R3: A frame qualifies when its destination is any of the following:
  - an address with bit 0 of its first byte set, which includes broadcast;
  - equal to `station_addr`;
  - equal to supplemental address i, when `supp_en[i]` is 1. Address i occupies `supp_addr[48*i +: 48]`.
  Any other destination never wakes the node.
- R4: The wake pattern is six 0xFF bytes followed by sixteen consecutive copies of the station address. It may start at any byte after the first 12 bytes of the frame.
- R5: A byte that breaks the pattern restarts the search. If that byte is 0xFF, it counts as the first byte of a new synchronisation run, so a pattern that overlaps a failed attempt is still found.
- R6: A detection is reported only on the byte carrying `rx_eof`. A frame followed by a new `rx_sof` before its end byte never reports.
- R7: `wake_pulse` is high for exactly the one cycle after the clock edge that accepts the qualifying end byte.
- R8: `wake_status` is set together with `wake_pulse`. It stays set until a cycle with `wake_clr` high, and that clear does not affect `magic_det`.
- R9: `magic_det` is set together with `wake_pulse`. It stays high until the cycle after `cfg_magic_en` is low or sleep is left.
- R10: Leaving detection mode discards any partial match. After re-entry, only a frame that begins with `rx_sof` can wake the node.
- R11: Address bytes are compared in wire order. The first byte of an address is bits [47:40], and the last is bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Received byte |
| cfg_sleep | input | 1 | Control bit requesting sleep |
| cfg_magic_en | input | 1 | Control bit enabling wake pattern detection |
| ext_stop | input | 1 | External pin forcing sleep |
| station_addr | input | 48 | Primary station address |
| supp_addr | input | 192 | Four supplemental unicast addresses, 48 bits each |
| supp_en | input | 4 | Enable for each supplemental address |
| wake_clr | input | 1 | Write-1 clear of wake_status |
| wake_pulse | output | 1 | One-cycle wake-up interrupt pulse |
| wake_status | output | 1 | Sticky wake-up interrupt status |
| magic_det | output | 1 | Detect pin, held while detection mode persists |
| sleep_active | output | 1 | Node is in sleep mode |
| tx_disable | output | 1 | Holds transmit logic off |
| fifo_disable | output | 1 | Holds receive and transmit FIFOs off |
| stat_inhibit | output | 1 | Blocks statistics counting |

## Verification
The destination filter is swept with eight destination kinds under all sixteen supplemental-enable masks. This separates group, broadcast, primary and per-slot matches from rejected unicast addresses. Mode inputs are swept in all eight sleep, stop and enable combinations, each at several pattern offsets. This shows whether the gating and the activation condition depend on the right inputs, and whether the pattern is found regardless of its position. Directed frames cover the following cases: a short sync run; one missing copy; a break on a 0xFF byte, which tells whether overlapping runs are handled; byte-reversed addresses; a frame aborted by a new start; and a frame split across a sleep exit, which tells whether a stale partial match survives.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int MAC_W      = 48;
    localparam int ADDR_BYTES = MAC_W / 8;
    localparam int HDR_LEN    = 2 * ADDR_BYTES;

    typedef enum logic [2:0] {
        ST_OFF, ST_WAIT, ST_HDR, ST_SKIP, ST_SYNC, ST_ADDR, ST_FOUND
    } match_state_t;

    // byte i of an address in wire order, byte 0 = bits [47:40]
    function automatic logic [7:0] addr_byte(input logic [MAC_W-1:0] a, input logic [2:0] i);
        return 8'(a >> (6'd40 - {i, 3'b000}));
    endfunction
endpackage

// File: rtl/wake_dest_filter.sv
module wake_dest_filter
    import wake_pkg::*;
#(
    parameter int N_SUPP = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    take,
    input  logic                    first,
    input  logic [2:0]              idx,
    input  logic [7:0]              data,
    input  logic [MAC_W-1:0]        station,
    input  logic [N_SUPP*MAC_W-1:0] supp,
    input  logic [N_SUPP-1:0]       supp_en,
    output logic                    dest_ok
);
    logic              grp_q;
    logic              pri_q;
    logic [N_SUPP-1:0] sup_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= 1'b0;
            pri_q <= 1'b0;
        end else if (clr) begin
            grp_q <= 1'b0;
            pri_q <= 1'b0;
        end else if (take) begin
            if (first) begin
                grp_q <= data[0];
                pri_q <= (data == addr_byte(station, idx));
            end else begin
                pri_q <= pri_q && (data == addr_byte(station, idx));
            end
        end
    end

    for (genvar g = 0; g < N_SUPP; g++) begin : g_supp
        logic [MAC_W-1:0] one_addr;
        assign one_addr = supp[g*MAC_W +: MAC_W];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sup_q[g] <= 1'b0;
            else if (clr)
                sup_q[g] <= 1'b0;
            else if (take)
                sup_q[g] <= (first || sup_q[g]) && (data == addr_byte(one_addr, idx));
        end
    end

    assign dest_ok = grp_q || pri_q || |(sup_q & supp_en);
endmodule

// File: rtl/wake_magic_fsm.sv
module wake_magic_fsm
    import wake_pkg::*;
#(
    parameter int SYNC_LEN = 6,
    parameter int COPIES   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             rx_sof,
    input  logic             rx_valid,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic [MAC_W-1:0] station,
    input  logic             dest_ok,
    output logic             filt_take,
    output logic             filt_first,
    output logic [2:0]       filt_idx,
    output logic             detect
);
    localparam int SW = $clog2(SYNC_LEN + 1);
    localparam int CW = $clog2(COPIES + 1);
    localparam int HW = $clog2(HDR_LEN + 1);

    match_state_t   state_q, state_n;
    logic [HW-1:0]  hdr_q, hdr_n;
    logic [SW-1:0]  sync_q, sync_n;
    logic [2:0]     byte_q, byte_n;
    logic [CW-1:0]  copy_q, copy_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            hdr_q   <= '0;
            sync_q  <= '0;
            byte_q  <= '0;
            copy_q  <= '0;
        end else begin
            state_q <= state_n;
            hdr_q   <= hdr_n;
            sync_q  <= sync_n;
            byte_q  <= byte_n;
            copy_q  <= copy_n;
        end
    end

    always_comb begin
        state_n    = state_q;
        hdr_n      = hdr_q;
        sync_n     = sync_q;
        byte_n     = byte_q;
        copy_n     = copy_q;
        filt_take  = 1'b0;
        filt_first = 1'b0;
        filt_idx   = hdr_q[2:0];
        detect     = 1'b0;
        if (!active) begin
            state_n = ST_OFF;
            hdr_n   = '0;
            sync_n  = '0;
            byte_n  = '0;
            copy_n  = '0;
        end else if (state_q == ST_OFF) begin
            state_n = ST_WAIT;
        end else if (rx_valid) begin
            if (rx_sof) begin
                state_n    = ST_HDR;
                hdr_n      = HW'(1);
                sync_n     = '0;
                byte_n     = '0;
                copy_n     = '0;
                filt_take  = 1'b1;
                filt_first = 1'b1;
                filt_idx   = 3'd0;
            end else begin
                unique case (state_q)
                    ST_HDR: begin
                        if (hdr_q < HW'(ADDR_BYTES))
                            filt_take = 1'b1;
                        if (hdr_q == HW'(ADDR_BYTES) && !dest_ok)
                            state_n = ST_SKIP;
                        else if (hdr_q == HW'(HDR_LEN - 1)) begin
                            state_n = ST_SYNC;
                            sync_n  = '0;
                        end
                        hdr_n = hdr_q + HW'(1);
                    end
                    ST_SYNC: begin
                        if (sync_q == SW'(SYNC_LEN) && rx_data == addr_byte(station, 3'd0)) begin
                            state_n = ST_ADDR;
                            byte_n  = 3'd1;
                            copy_n  = '0;
                        end else if (rx_data == 8'hFF) begin
                            if (sync_q != SW'(SYNC_LEN))
                                sync_n = sync_q + SW'(1);
                        end else begin
                            sync_n = '0;
                        end
                    end
                    ST_ADDR: begin
                        if (rx_data == addr_byte(station, byte_q)) begin
                            if (byte_q == 3'(ADDR_BYTES - 1)) begin
                                byte_n = 3'd0;
                                if (copy_q == CW'(COPIES - 1))
                                    state_n = ST_FOUND;
                                else
                                    copy_n = copy_q + CW'(1);
                            end else begin
                                byte_n = byte_q + 3'd1;
                            end
                        end else begin
                            state_n = ST_SYNC;
                            sync_n  = (rx_data == 8'hFF) ? SW'(1) : '0;
                            byte_n  = 3'd0;
                            copy_n  = '0;
                        end
                    end
                    ST_OFF, ST_WAIT, ST_SKIP, ST_FOUND: ;
                    default: ;
                endcase
            end
            if (rx_eof) begin
                detect  = (state_n == ST_FOUND);
                state_n = ST_WAIT;
            end
        end
    end

    AST_DETECT_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        detect |-> (rx_valid && rx_eof)); // R6
    AST_DETECT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        detect |-> active); // R2
    AST_OFF_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state_q == ST_OFF)); // R10
endmodule

// File: rtl/sleep_wake_detector.sv
module sleep_wake_detector
    import wake_pkg::*;
#(
    parameter int N_SUPP   = 4,
    parameter int SYNC_LEN = 6,
    parameter int COPIES   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_sof,
    input  logic                    rx_valid,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    input  logic                    cfg_sleep,
    input  logic                    cfg_magic_en,
    input  logic                    ext_stop,
    input  logic [MAC_W-1:0]        station_addr,
    input  logic [N_SUPP*MAC_W-1:0] supp_addr,
    input  logic [N_SUPP-1:0]       supp_en,
    input  logic                    wake_clr,
    output logic                    wake_pulse,
    output logic                    wake_status,
    output logic                    magic_det,
    output logic                    sleep_active,
    output logic                    tx_disable,
    output logic                    fifo_disable,
    output logic                    stat_inhibit
);
    logic       asleep;
    logic       active;
    logic       dest_ok;
    logic       f_take;
    logic       f_first;
    logic [2:0] f_idx;
    logic       detect;

    assign asleep       = cfg_sleep || ext_stop;
    assign active       = asleep && cfg_magic_en;
    assign sleep_active = asleep;
    assign tx_disable   = asleep;
    assign fifo_disable = asleep;
    assign stat_inhibit = asleep;

    wake_dest_filter #(.N_SUPP(N_SUPP)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!active),
        .take    (f_take),
        .first   (f_first),
        .idx     (f_idx),
        .data    (rx_data),
        .station (station_addr),
        .supp    (supp_addr),
        .supp_en (supp_en),
        .dest_ok (dest_ok)
    );

    wake_magic_fsm #(.SYNC_LEN(SYNC_LEN), .COPIES(COPIES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .rx_sof     (rx_sof),
        .rx_valid   (rx_valid),
        .rx_eof     (rx_eof),
        .rx_data    (rx_data),
        .station    (station_addr),
        .dest_ok    (dest_ok),
        .filt_take  (f_take),
        .filt_first (f_first),
        .filt_idx   (f_idx),
        .detect     (detect)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_pulse  <= 1'b0;
            wake_status <= 1'b0;
            magic_det   <= 1'b0;
        end else begin
            wake_pulse <= detect;
            if (detect)
                wake_status <= 1'b1;
            else if (wake_clr)
                wake_status <= 1'b0;
            if (!active)
                magic_det <= 1'b0;
            else if (detect)
                magic_det <= 1'b1;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R7
    AST_PULSE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> wake_status); // R8
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_status && !wake_clr) |=> wake_status); // R8
    AST_DET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(asleep && cfg_magic_en) |=> !magic_det); // R9
endmodule

// File: tb/sleep_wake_detector_tb.sv
module sleep_wake_detector_tb;
    localparam logic [47:0] ST  = 48'h02_11_22_33_44_54;
    localparam logic [47:0] SRC = 48'h02_AA_BB_CC_DD_EE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0;
    logic [7:0] rx_data = '0;
    logic cfg_sleep = 1'b0, cfg_magic_en = 1'b0, ext_stop = 1'b0;
    logic [191:0] supp_addr;
    logic [3:0] supp_en = '0;
    logic wake_clr = 1'b0;
    logic wake_pulse, wake_status, magic_det, sleep_active, tx_disable, fifo_disable, stat_inhibit;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] frm [0:511];
    int flen;
    logic got_pulse, got_after;

    always #5 clk = ~clk;

    sleep_wake_detector u_dut (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_eof(rx_eof),
        .rx_data(rx_data), .cfg_sleep(cfg_sleep), .cfg_magic_en(cfg_magic_en),
        .ext_stop(ext_stop), .station_addr(ST), .supp_addr(supp_addr), .supp_en(supp_en),
        .wake_clr(wake_clr), .wake_pulse(wake_pulse), .wake_status(wake_status),
        .magic_det(magic_det), .sleep_active(sleep_active), .tx_disable(tx_disable),
        .fifo_disable(fifo_disable), .stat_inhibit(stat_inhibit)
    );

    function automatic logic [47:0] supp_of(input int i);
        return 48'h0A_BC_00_00_00_00 | 48'(i + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        frm[flen] = b;
        flen++;
    endtask

    task automatic put_addr(input logic [47:0] a);
        for (int k = 0; k < 6; k++) put(a[8*(5-k) +: 8]);
    endtask

    task automatic put_magic(input int nff, input int ncopies, input logic [47:0] a);
        for (int k = 0; k < nff; k++) put(8'hFF);
        for (int c = 0; c < ncopies; c++) put_addr(a);
    endtask

    task automatic start_frame(input logic [47:0] dest, input int nfill);
        flen = 0;
        put_addr(dest);
        put_addr(SRC);
        for (int k = 0; k < nfill; k++) put(8'(k + 1));
    endtask

    task automatic finish_frame();
        for (int k = 0; k < 4; k++) put(8'h00);
    endtask

    task automatic send_part(input int lo, input int hi, input bit sof, input bit eof);
        for (int i = lo; i < hi; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = sof && (i == lo);
            rx_eof   = eof && (i == hi - 1);
            rx_data  = frm[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        got_pulse = wake_pulse;
        @(negedge clk);
        got_after = wake_pulse;
    endtask

    task automatic send_std(input logic [47:0] dest, input int nfill);
        start_frame(dest, nfill);
        put_magic(6, 16, ST);
        finish_frame();
        send_part(0, flen, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] dests [0:7];
        for (int i = 0; i < 4; i++) supp_addr[48*i +: 48] = supp_of(i);
        dests[0] = 48'h01_00_5E_00_00_01;
        dests[1] = 48'hFF_FF_FF_FF_FF_FF;
        dests[2] = ST;
        for (int i = 0; i < 4; i++) dests[3+i] = supp_of(i);
        dests[7] = 48'h0A_BC_00_00_00_09;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wake_pulse && !wake_status && !magic_det && !sleep_active, "reset R1",
            {wake_pulse, wake_status, magic_det, sleep_active}, 0);

        // R3: destination sweep over all supplemental masks
        cfg_sleep = 1'b1;
        cfg_magic_en = 1'b1;
        for (int m = 0; m < 16; m++) begin
            supp_en = 4'(m);
            for (int d = 0; d < 8; d++) begin
                bit exp;
                exp = (d < 3) || (d >= 3 && d < 7 && m[d-3]);
                send_std(dests[d], 0);
                chk(got_pulse == exp, $sformatf("R3 dest %0d mask %0d", d, m), got_pulse, exp);
                chk(!got_after, "R7 pulse width", got_after, 0);
            end
        end
        supp_en = 4'b0000;

        // R1/R2/R4: mode combinations at several offsets
        for (int md = 0; md < 8; md++) begin
            for (int off = 0; off < 8; off++) begin
                bit exp;
                cfg_sleep = md[0];
                ext_stop = md[1];
                cfg_magic_en = md[2];
                exp = (md[0] | md[1]) & md[2];
                @(negedge clk);
                chk({sleep_active, tx_disable, fifo_disable, stat_inhibit} == {4{md[0] | md[1]}},
                    "R1 gating", {sleep_active, tx_disable, fifo_disable, stat_inhibit}, {4{md[0] | md[1]}});
                send_std(ST, off * 5);
                chk(got_pulse == exp, $sformatf("R2 R4 mode %0d off %0d", md, off), got_pulse, exp);
            end
        end
        cfg_sleep = 1'b0;
        ext_stop = 1'b1;
        cfg_magic_en = 1'b1;
        @(negedge clk);
        ext_stop = 1'b0;
        @(negedge clk);
        chk(!sleep_active, "R1 stop release", sleep_active, 0);

        cfg_sleep = 1'b1;
        repeat (2) @(negedge clk);
        // R4: short sync run
        start_frame(ST, 3); put_magic(5, 16, ST); finish_frame();
        send_part(0, flen, 1'b1, 1'b1);
        chk(!got_pulse, "R4 five sync bytes", got_pulse, 0);
        // R4: fifteen copies
        start_frame(ST, 3); put_magic(6, 15, ST); finish_frame();
        send_part(0, flen, 1'b1, 1'b1);
        chk(!got_pulse, "R4 fifteen copies", got_pulse, 0);
        // R4: longer sync run is accepted
        start_frame(ST, 2); put_magic(9, 16, ST); finish_frame();
        send_part(0, flen, 1'b1, 1'b1);
        chk(got_pulse, "R4 long sync", got_pulse, 1);
        // R5: break on 0xFF that begins a new run
        start_frame(ST, 1); put_magic(6, 5, ST); put_magic(6, 16, ST); finish_frame();
        send_part(0, flen, 1'b1, 1'b1);
        chk(got_pulse, "R5 overlap restart", got_pulse, 1);
        // R5: break on non-0xFF then full pattern
        start_frame(ST, 1); put_magic(6, 7, ST); put(8'h12); put_magic(6, 16, ST); finish_frame();
        send_part(0, flen, 1'b1, 1'b1);
        chk(got_pulse, "R5 restart after junk", got_pulse, 1);
        // R11: byte-reversed copies
        start_frame(ST, 0); put_magic(6, 16, 48'h54_44_33_22_11_02); finish_frame();
        send_part(0, flen, 1'b1, 1'b1);
        chk(!got_pulse, "R11 reversed copies", got_pulse, 0);
        // R11: byte-reversed destination
        start_frame(48'h54_44_33_22_11_02, 0); put_magic(6, 16, ST); finish_frame();
        send_part(0, flen, 1'b1, 1'b1);
        chk(!got_pulse, "R11 reversed destination", got_pulse, 0);
        // R6: pattern complete but no end byte, then a new short frame
        start_frame(ST, 0); put_magic(6, 16, ST); finish_frame();
        send_part(0, flen, 1'b1, 1'b0);
        chk(!got_pulse, "R6 no eof", got_pulse, 0);
        start_frame(ST, 2); finish_frame();
        send_part(0, flen, 1'b1, 1'b1);
        chk(!got_pulse, "R6 aborted frame", got_pulse, 0);
        // R6: eof on last copy byte
        start_frame(ST, 0); put_magic(6, 16, ST);
        send_part(0, flen, 1'b1, 1'b1);
        chk(got_pulse, "R6 eof on last copy", got_pulse, 1);

        // R8/R9 sticky behaviour
        chk(wake_status && magic_det, "R8 R9 set", {wake_status, magic_det}, 2'b11);
        @(negedge clk); wake_clr = 1'b1;
        @(negedge clk); wake_clr = 1'b0;
        chk(!wake_status && magic_det, "R8 clear independent", {wake_status, magic_det}, 2'b01);
        send_std(ST, 0);
        chk(wake_status, "R8 set again", wake_status, 1);
        cfg_magic_en = 1'b0;
        @(negedge clk);
        chk(!magic_det && wake_status, "R9 enable cleared", {magic_det, wake_status}, 2'b01);
        cfg_magic_en = 1'b1;
        send_std(ST, 0);
        chk(magic_det, "R9 set", magic_det, 1);
        cfg_sleep = 1'b0;
        @(negedge clk);
        chk(!magic_det, "R9 sleep exit", magic_det, 0);

        // R10: frame split across a sleep exit
        cfg_sleep = 1'b1;
        repeat (2) @(negedge clk);
        start_frame(ST, 0); put_magic(6, 16, ST); finish_frame();
        send_part(0, 40, 1'b1, 1'b0);
        cfg_sleep = 1'b0;
        repeat (3) @(negedge clk);
        cfg_sleep = 1'b1;
        repeat (2) @(negedge clk);
        send_part(40, flen, 1'b0, 1'b1);
        chk(!got_pulse, "R10 stale partial match", got_pulse, 0);
        send_std(ST, 0);
        chk(got_pulse, "R10 fresh frame after re-entry", got_pulse, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule